// File: doc/BRIEF.md
# Lockable Instruction Cache Controller

This block sits between a processor's instruction fetch port and a slow flash array that draws significant current on every read. It keeps recently fetched code in on-chip line storage, answering repeat fetches from that storage in the request cycle and reaching out to flash only when the requested line is absent. The organisation is direct-mapped: 16 lines, each holding 4 words of 32 bits, addressed by a word address.

Software may pin any resident line through a small register port. A pinned line is never overwritten, so code such as an interrupt handler stays resident no matter what the main program runs, and its fetch time stays fixed. When a miss lands on a pinned line, the word fetched from flash is handed to the processor but not stored. A single release command drops every pin at once, returning the whole cache to ordinary replacement, which suits a system waking from a slow idle mode. The same port reads back saturating counters of hits and misses.

Top module: `lockable_icache`

## Requirements
- R1: A fetch whose line is resident and whose tag matches completes in its request cycle (`cpu_ready` high, correct word on `cpu_rdata`) and raises no `flash_rd`.
- R2: A fetch that misses raises `flash_rd` for exactly one cycle, in the request cycle, with `flash_addr` equal to the word address without its two low bits; `cpu_ready` then stays low until the cycle `flash_valid` is high, where word `cpu_addr[1:0]` of `flash_rdata` (word k at bits 32k+31:32k) is returned. With a 4-cycle flash this is 4 cycles after the request cycle.
- R3: A miss on an unlocked line stores the fetched line there, replacing any line of another tag at that index; later fetches to the new line hit and fetches to the old tag miss.
- R4: A locked line is never replaced: a miss mapping onto it returns the flash word but allocates nothing, so the same address misses again and the locked line keeps hitting.
- R5: A lock request (`lock_we` with `lock_idx`) pins the line only if that line is valid at that clock edge or is being filled at that same edge; a request on an invalid line has no effect.
- R6: `unlock_all` clears every lock bit; when it coincides with a lock request, the release wins and no line stays locked.
- R7: The hit and miss counters are 16 bits wide, count one per completed hit and one per miss, and stop at 65535 without wrapping.
- R8: After reset every line is invalid and unlocked, both counters read 0 and `cpu_ready` is low while no fetch is requested.
- R9: `stat_data` shows the hit counter when `stat_sel` is 0 and the miss counter when `stat_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Fetch request, held until `cpu_ready` |
| cpu_addr | input | 12 | Word address of the fetch |
| cpu_rdata | output | 32 | Fetched instruction word |
| cpu_ready | output | 1 | Fetch completes this cycle |
| flash_rd | output | 1 | One-cycle flash line read request |
| flash_addr | output | 10 | Line address of the flash read |
| flash_valid | input | 1 | Flash line data valid this cycle |
| flash_rdata | input | 128 | Flash line, word 0 in the low bits |
| lock_we | input | 1 | Lock request strobe |
| lock_idx | input | 4 | Line index to lock |
| unlock_all | input | 1 | Release every lock |
| stat_sel | input | 1 | Counter select: 0 hits, 1 misses |
| stat_data | output | 16 | Selected counter value |

## Verification
The two functions that can fall in one clock edge are a line fill and a lock request for the same index, and separately a release and a lock request. The bench raises `lock_we` exactly in the cycle where the flash data returns for a missing line, then proves the lock took hold by sending a conflicting miss and seeing the original line still hit. It also pulses `unlock_all` together with a lock of a valid line and judges the outcome by showing that conflicting misses replace both that line and a previously locked one.

// File: rtl/icl_pkg.sv
// Package for the lockable instruction cache.
// Holds the miss controller's state type shared by its modules.
package icl_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } fetch_state_t;
endpackage

// File: rtl/icl_sat_counter.sv
// Saturating event counter.
// Assumes inc is a single-cycle event flag; the value holds at all ones.
module icl_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic [W-1:0] cnt_q;

    // Count events, stopping at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (inc && cnt_q != MAXV)
            cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == MAXV) |=> (cnt_q == MAXV));

    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt_q != MAXV) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/icl_tag_store.sv
// Per-line valid, tag and lock state of the direct-mapped cache.
// Assumes a fill is only requested for a line that is not locked.
module icl_tag_store #(
    parameter int LINES = 16,
    parameter int TAG_W = 6,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] look_idx,
    output logic             look_valid,
    output logic [TAG_W-1:0] look_tag,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    output logic             fill_locked,
    input  logic             lock_we,
    input  logic [IDX_W-1:0] lock_idx,
    input  logic             unlock_all
);
    logic             valid_a [LINES];
    logic             lock_a  [LINES];
    logic [TAG_W-1:0] tag_a   [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic             v_q;
        logic             l_q;
        logic [TAG_W-1:0] t_q;
        logic             fill_here;
        logic             lock_here;

        assign fill_here = fill_en && (fill_idx == IDX_W'(g));
        assign lock_here = lock_we && (lock_idx == IDX_W'(g));

        // Track validity and tag; a fill overwrites this line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                t_q <= '0;
            end else if (fill_here) begin
                v_q <= 1'b1;
                t_q <= fill_tag;
            end
        end

        // Track the pin; release wins, a pin needs a valid or filling line.
        always_ff @(posedge clk) begin
            if (!rst_n)
                l_q <= 1'b0;
            else if (unlock_all)
                l_q <= 1'b0;
            else if (lock_here && (v_q || fill_here))
                l_q <= 1'b1;
        end

        assign valid_a[g] = v_q;
        assign lock_a[g]  = l_q;
        assign tag_a[g]   = t_q;

        assert_locked_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (l_q && !unlock_all) |=> (v_q && $stable(t_q)));

        assert_lock_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
            l_q |-> v_q);
    end

    assign look_valid  = valid_a[look_idx];
    assign look_tag    = tag_a[look_idx];
    assign fill_locked = lock_a[fill_idx];
endmodule

// File: rtl/icl_line_store.sv
// Line data storage of the cache, one register line per index.
// Assumes the fill line carries word 0 in its low bits.
module icl_line_store #(
    parameter int LINES  = 16,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W  = $clog2(LINES),
    localparam int OFF_W  = $clog2(WORDS),
    localparam int LINE_W = DATA_W * WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [LINE_W-1:0] fill_line,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_word,
    output logic [DATA_W-1:0] rd_data
);
    logic [LINE_W-1:0] line_a [LINES];
    logic [LINE_W-1:0] rd_line;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [LINE_W-1:0] d_q;

        // Capture a whole line when it is filled.
        always_ff @(posedge clk) begin
            if (!rst_n)
                d_q <= '0;
            else if (fill_en && fill_idx == IDX_W'(g))
                d_q <= fill_line;
        end

        assign line_a[g] = d_q;
    end

    assign rd_line = line_a[rd_idx];
    assign rd_data = rd_line[rd_word*DATA_W +: DATA_W];
endmodule

// File: rtl/icl_miss_ctrl.sv
// Fetch sequencer: answers hits at once, runs one flash read per miss.
// Assumes the CPU holds request and address until ready, and the flash
// raises flash_valid once per read request.
module icl_miss_ctrl
    import icl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int LINES  = 16,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W  = $clog2(LINES),
    localparam int OFF_W  = $clog2(WORDS),
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
    localparam int LINE_W = DATA_W * WORDS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_req,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic                hit,
    input  logic [DATA_W-1:0]   hit_word,
    input  logic                flash_valid,
    input  logic [LINE_W-1:0]   flash_rdata,
    input  logic                fill_locked,
    output logic                cpu_ready,
    output logic [DATA_W-1:0]   cpu_rdata,
    output logic                flash_rd,
    output logic [ADDR_W-OFF_W-1:0] flash_addr,
    output logic                fill_en,
    output logic [IDX_W-1:0]    fill_idx,
    output logic [TAG_W-1:0]    fill_tag,
    output logic                hit_evt,
    output logic                miss_evt
);
    fetch_state_t      state_q;
    logic [ADDR_W-1:0] pend_q;
    logic [OFF_W-1:0]  pend_word;
    logic              idle;

    assign idle      = (state_q == ST_IDLE);
    assign hit_evt   = idle && cpu_req && hit;
    assign miss_evt  = idle && cpu_req && !hit;
    assign flash_rd  = miss_evt;
    assign flash_addr = cpu_addr[ADDR_W-1:OFF_W];

    assign pend_word = pend_q[OFF_W-1:0];
    assign fill_idx  = pend_q[OFF_W +: IDX_W];
    assign fill_tag  = pend_q[ADDR_W-1 -: TAG_W];
    assign fill_en   = !idle && flash_valid && !fill_locked;

    assign cpu_ready = hit_evt || (!idle && flash_valid);
    assign cpu_rdata = idle ? hit_word : flash_rdata[pend_word*DATA_W +: DATA_W];

    // Enter the wait state on a miss and leave it when flash data returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
        end else if (idle) begin
            if (miss_evt) begin
                state_q <= ST_WAIT;
                pend_q  <= cpu_addr;
            end
        end else if (flash_valid) begin
            state_q <= ST_IDLE;
        end
    end

    assert_single_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flash_rd |=> !flash_rd);

    assert_miss_waits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flash_rd |=> !cpu_ready || flash_valid);
endmodule

// File: rtl/lockable_icache.sv
// Direct-mapped instruction cache in front of a slow flash, with per-line
// pins that keep lines from replacement and a global release.
// Assumes the CPU holds cpu_req and cpu_addr until cpu_ready.
module lockable_icache #(
    parameter int ADDR_W = 12,
    parameter int LINES  = 16,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    localparam int IDX_W  = $clog2(LINES),
    localparam int OFF_W  = $clog2(WORDS),
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
    localparam int LINE_W = DATA_W * WORDS,
    localparam int LA_W   = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              flash_rd,
    output logic [LA_W-1:0]   flash_addr,
    input  logic              flash_valid,
    input  logic [LINE_W-1:0] flash_rdata,
    input  logic              lock_we,
    input  logic [IDX_W-1:0]  lock_idx,
    input  logic              unlock_all,
    input  logic              stat_sel,
    output logic [CNT_W-1:0]  stat_data
);
    logic [IDX_W-1:0]  cpu_idx;
    logic [TAG_W-1:0]  cpu_tag;
    logic              look_valid;
    logic [TAG_W-1:0]  look_tag;
    logic              hit;
    logic [DATA_W-1:0] hit_word;
    logic              fill_en;
    logic [IDX_W-1:0]  fill_idx;
    logic [TAG_W-1:0]  fill_tag;
    logic              fill_locked;
    logic              hit_evt;
    logic              miss_evt;
    logic [CNT_W-1:0]  hit_cnt;
    logic [CNT_W-1:0]  miss_cnt;

    assign cpu_idx = cpu_addr[OFF_W +: IDX_W];
    assign cpu_tag = cpu_addr[ADDR_W-1 -: TAG_W];
    assign hit     = look_valid && (look_tag == cpu_tag);

    icl_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk         (clk),
        .rst_n       (rst_n),
        .look_idx    (cpu_idx),
        .look_valid  (look_valid),
        .look_tag    (look_tag),
        .fill_en     (fill_en),
        .fill_idx    (fill_idx),
        .fill_tag    (fill_tag),
        .fill_locked (fill_locked),
        .lock_we     (lock_we),
        .lock_idx    (lock_idx),
        .unlock_all  (unlock_all)
    );

    icl_line_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_en   (fill_en),
        .fill_idx  (fill_idx),
        .fill_line (flash_rdata),
        .rd_idx    (cpu_idx),
        .rd_word   (cpu_addr[OFF_W-1:0]),
        .rd_data   (hit_word)
    );

    icl_miss_ctrl #(.ADDR_W(ADDR_W), .LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_req     (cpu_req),
        .cpu_addr    (cpu_addr),
        .hit         (hit),
        .hit_word    (hit_word),
        .flash_valid (flash_valid),
        .flash_rdata (flash_rdata),
        .fill_locked (fill_locked),
        .cpu_ready   (cpu_ready),
        .cpu_rdata   (cpu_rdata),
        .flash_rd    (flash_rd),
        .flash_addr  (flash_addr),
        .fill_en     (fill_en),
        .fill_idx    (fill_idx),
        .fill_tag    (fill_tag),
        .hit_evt     (hit_evt),
        .miss_evt    (miss_evt)
    );

    icl_sat_counter #(.W(CNT_W)) u_hit_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (hit_evt),
        .count (hit_cnt)
    );

    icl_sat_counter #(.W(CNT_W)) u_miss_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (miss_evt),
        .count (miss_cnt)
    );

    // Select which counter the register port shows.
    always_comb begin
        stat_data = stat_sel ? miss_cnt : hit_cnt;
    end

    assert_hit_no_flash_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && hit && cpu_ready) |-> !flash_rd);
endmodule

// File: tb/lockable_icache_test.sv
// Directed bench for the lockable instruction cache with a 4-cycle flash model.
module lockable_icache_test;
    localparam int CLK_PERIOD = 10;
    localparam int FLASH_LAT  = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req = 1'b0;
    logic [11:0]  cpu_addr = '0;
    logic [31:0]  cpu_rdata;
    logic         cpu_ready;
    logic         flash_rd;
    logic [9:0]   flash_addr;
    logic         flash_valid;
    logic [127:0] flash_rdata;
    logic         lock_we = 1'b0;
    logic [3:0]   lock_idx = '0;
    logic         unlock_all = 1'b0;
    logic         stat_sel = 1'b0;
    logic [15:0]  stat_data;

    int errors = 0;
    int checks = 0;
    int flash_reads = 0;
    int exp_hits = 0;
    int exp_misses = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lockable_icache uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .flash_rd(flash_rd),
        .flash_addr(flash_addr), .flash_valid(flash_valid), .flash_rdata(flash_rdata),
        .lock_we(lock_we), .lock_idx(lock_idx), .unlock_all(unlock_all),
        .stat_sel(stat_sel), .stat_data(stat_data)
    );

    function automatic logic [31:0] fword(input logic [9:0] line, input logic [1:0] w);
        return 32'h5A00_0003 | (32'(line) << 8) | (32'(w) << 4);
    endfunction

    // Flash model: data valid FLASH_LAT cycles after the read request cycle.
    int          fl_cnt = 0;
    logic [9:0]  fl_line = '0;
    always @(posedge clk) begin
        if (flash_rd) begin
            fl_cnt <= FLASH_LAT;
            fl_line <= flash_addr;
            flash_reads <= flash_reads + 1;
        end else if (fl_cnt != 0) begin
            fl_cnt <= fl_cnt - 1;
        end
    end
    assign flash_valid = (fl_cnt == 1);
    assign flash_rdata = {fword(fl_line, 2'd3), fword(fl_line, 2'd2),
                          fword(fl_line, 2'd1), fword(fl_line, 2'd0)};

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] mk(input int tag, input int idx, input int w);
        return {6'(tag), 4'(idx), 2'(w)};
    endfunction

    // One fetch; checks latency, data and flash traffic against the expectation.
    task automatic fetch(input int tag, input int idx, input int w, input bit exp_hit,
                         input string req);
        int n = 0;
        int f0;
        logic [31:0] d;
        logic [11:0] a = mk(tag, idx, w);
        @(negedge clk);
        f0 = flash_reads;
        cpu_req = 1'b1;
        cpu_addr = a;
        #1;
        while (!cpu_ready && n < 50) begin
            @(negedge clk);
            n++;
            #1;
        end
        d = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0;
        check(n == (exp_hit ? 0 : FLASH_LAT), req, "latency", n, exp_hit ? 0 : FLASH_LAT);
        check(d == fword(a[11:2], a[1:0]), req, "data", d, fword(a[11:2], a[1:0]));
        check((flash_reads - f0) == (exp_hit ? 0 : 1), req, "flash reads",
              flash_reads - f0, exp_hit ? 0 : 1);
        if (exp_hit) exp_hits++; else exp_misses++;
    endtask

    task automatic lock_line(input int idx, input bit rel);
        @(negedge clk);
        lock_we = 1'b1;
        lock_idx = 4'(idx);
        unlock_all = rel;
        @(negedge clk);
        lock_we = 1'b0;
        unlock_all = 1'b0;
    endtask

    task automatic read_stats(input string req);
        int eh = (exp_hits > 65535) ? 65535 : exp_hits;
        int em = (exp_misses > 65535) ? 65535 : exp_misses;
        @(negedge clk);
        stat_sel = 1'b0;
        #1;
        check(int'(stat_data) == eh, req, "hit count", stat_data, eh);
        stat_sel = 1'b1;
        #1;
        check(int'(stat_data) == em, req, "miss count", stat_data, em);
        stat_sel = 1'b0;
    endtask

    task automatic t_reset;
        #1;
        check(cpu_ready == 1'b0, "R8", "ready idle", cpu_ready, 0);
        read_stats("R8 R9");
        fetch(1, 2, 1, 1'b0, "R8 invalid after reset");
    endtask

    task automatic t_miss_then_hit;
        fetch(1, 2, 3, 1'b1, "R1 hit in line");
        fetch(1, 2, 0, 1'b1, "R1 hit word0");
        fetch(3, 4, 2, 1'b0, "R2 miss");
        fetch(3, 4, 2, 1'b1, "R1 hit after fill");
    endtask

    task automatic t_replace;
        fetch(2, 2, 0, 1'b0, "R3 conflict miss");
        fetch(2, 2, 3, 1'b1, "R3 new line hits");
        fetch(1, 2, 1, 1'b0, "R3 old tag misses");
    endtask

    task automatic t_lock_invalid;
        lock_line(5, 1'b0);
        fetch(1, 5, 0, 1'b0, "R5 fill after void lock");
        fetch(2, 5, 0, 1'b0, "R5 conflict");
        fetch(1, 5, 0, 1'b0, "R5 line was not locked");
    endtask

    task automatic t_lock_keep;
        fetch(1, 8, 0, 1'b0, "R4 fill");
        lock_line(8, 1'b0);
        fetch(3, 8, 1, 1'b0, "R4 forward on locked");
        fetch(3, 8, 1, 1'b0, "R4 no allocation");
        fetch(1, 8, 2, 1'b1, "R4 locked line kept");
    endtask

    // Lock request placed in the very cycle the flash data fills line 6.
    task automatic t_lock_during_fill;
        int n = 0;
        @(negedge clk);
        cpu_req = 1'b1;
        cpu_addr = mk(1, 6, 0);
        #1;
        while (!cpu_ready && n < 50) begin
            @(negedge clk);
            n++;
            if (n == FLASH_LAT) begin
                lock_we = 1'b1;
                lock_idx = 4'd6;
            end
            #1;
        end
        check(n == FLASH_LAT, "R5 R2", "fill latency", n, FLASH_LAT);
        exp_misses++;
        @(negedge clk);
        cpu_req = 1'b0;
        lock_we = 1'b0;
        fetch(2, 6, 0, 1'b0, "R5 conflict on same-cycle lock");
        fetch(1, 6, 3, 1'b1, "R5 same-cycle lock held");
    endtask

    task automatic t_unlock;
        fetch(1, 7, 0, 1'b0, "R6 fill line 7");
        lock_line(7, 1'b1);
        fetch(2, 7, 0, 1'b0, "R6 release beats lock miss");
        fetch(1, 7, 0, 1'b0, "R6 line 7 replaced");
        fetch(2, 8, 0, 1'b0, "R6 line 8 miss");
        fetch(1, 8, 0, 1'b0, "R6 line 8 replaced");
        fetch(2, 6, 1, 1'b0, "R6 line 6 miss");
        fetch(1, 6, 1, 1'b0, "R6 line 6 replaced");
    endtask

    task automatic t_saturate;
        fetch(0, 0, 0, 1'b0, "R7 prime");
        @(negedge clk);
        cpu_req = 1'b1;
        cpu_addr = mk(0, 0, 1);
        repeat (65600) @(negedge clk);
        cpu_req = 1'b0;
        exp_hits += 65600;
        read_stats("R7 saturate");
        fetch(9, 0, 0, 1'b0, "R7 miss after saturate");
        read_stats("R7 R9 after saturate");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_miss_then_hit();
        t_replace();
        t_lock_invalid();
        t_lock_keep();
        t_lock_during_fill();
        t_unlock();
        read_stats("R7 R9 mid");
        t_saturate();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule